// File: doc/BRIEF.md
# Panel Power-Up Reset and Configuration Sequencer

This block brings a small TFT display panel from power-up to a running picture without software help. After a start request it first drives the panel's active-low reset line through a timed high–low–high pattern. Then it asks the serial command port for the panel's identity byte. That byte picks one of two stored configuration programs. The block sends the chosen program entry by entry and ends with a display-on command followed by a sleep-out command.

Each program entry has an opcode, a list of parameter bytes and a wait. The wait is counted in millisecond ticks and begins after the entry's last byte has been accepted. All timing comes from an external one-cycle millisecond tick. Each byte goes to the serial port as a 9-bit word: a flag bit that marks a parameter, followed by the byte itself. The port answers every word with a done pulse, which can carry an error indication.

Top module: `panel_init_seq`

## Requirements
- R1: After reset, `panel_rst_n_o` is high, and `xfer_req_o`, `busy_o`, `done_o` and `err_o` are all low.
- R2: When started, the sequencer holds `panel_rst_n_o` high for 100 ticks, then low for 40 ticks, then high for 100 ticks before it raises the first transfer request. No request is ever raised while `panel_rst_n_o` is low.
- R3: The first transfer after the reset pattern is an identity read. It has `xfer_rd_o`=1 and `xfer_word_o`=0x004. The returned `xfer_rdata_i` is taken on that transfer's done pulse.
- R4: An identity of 0x80 selects program A. Program A has 8 entries, with opcodes 0x36, 0x3A, 0xB6, 0xC5, 0xE0, 0xE1, 0xB0, 0xB4 and parameter counts 1, 1, 4, 2, 16, 16, 1, 1.
- R5: Any other identity selects program B, which has 22 entries. Entry 0 is opcode 0xFF with parameters 0xFF, 0x98, 0x06. Entry 21 is opcode 0x35 with one parameter 0x00. Each entry e from 1 to 20 is opcode 0xC0+e with two parameters.
- R6: Bit 8 of `xfer_word_o` is 0 for an opcode and 1 for a parameter; bits 7:0 carry the byte. Parameter k of entry e is {e[3:0], k[3:0]}, except where R5 fixes the value.
- R7: In program A, exactly 20 ticks pass between the done of the opcode-0xE1 entry's last byte and the next request. Exactly 100 ticks pass after the final entry (0xB4).
- R8: After the last program entry, opcode 0x29 is sent with no parameters. Then 100 ticks pass, and then opcode 0x11 is sent with no parameters.
- R9: `busy_o` is high from the cycle after start until the sleep-out transfer completes. `done_o` then pulses high for exactly one cycle, and that cycle is the first one with `busy_o` low.
- R10: A done pulse that carries `xfer_err_i` sets `err_o`. `err_o` stays set for the rest of the run, the sequence continues unchanged, and the flag clears at the next accepted start.
- R11: A start request received while `busy_o` is high has no effect on the reset pattern, the transfer stream or the done pulse.
- R12: Only one transfer is outstanding at a time. `xfer_req_o`, `xfer_rd_o` and `xfer_word_o` stay stable until the cycle in which `xfer_done_i` is seen, and the request drops after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start the power-up sequence (accepted when idle) |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| panel_rst_n_o | output | 1 | Active-low panel reset line |
| xfer_req_o | output | 1 | Transfer request to the serial command port |
| xfer_rd_o | output | 1 | Transfer is an identity read |
| xfer_word_o | output | 9 | Bit 8 parameter flag, bits 7:0 byte |
| xfer_done_i | input | 1 | Port has finished the current transfer |
| xfer_err_i | input | 1 | Port error, valid with done |
| xfer_rdata_i | input | 8 | Identity byte, valid with done of a read |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at completion |
| err_o | output | 1 | Sticky error flag for the current run |

## Verification
A wrong program or entry index shows up on the very next request, because the opcode or parameter word no longer matches the scoreboard entry for that position. A wrong parameter counter shows up as one word too many or too few, which shifts every later word in the stream. A timer or phase fault changes the number of ticks between a reset-line edge or a done pulse and the next event, so it is caught at the end of that wait, after at most 100 ticks. A lost or spurious restart gives a wrong reset-low duration, a second done pulse, or words left in the queue when done arrives.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

    // Program geometry, fixed by the stored programs
    localparam int PROG_A_LEN  = 8;
    localparam int PROG_B_LEN  = 22;
    localparam int TAIL_LEN    = 2;
    localparam int STEP_MAX    = PROG_B_LEN + TAIL_LEN;
    localparam int STEP_W      = $clog2(STEP_MAX);
    localparam int MAX_PARAMS  = 16;
    localparam int PIDX_W      = $clog2(MAX_PARAMS + 1);
    localparam int BYTE_W      = 8;
    localparam int WORD_W      = BYTE_W + 1;

    // Fixed opcodes and waits
    localparam logic [BYTE_W-1:0] OPC_DISP_ON   = 8'h29;
    localparam logic [BYTE_W-1:0] OPC_SLEEP_OUT = 8'h11;
    localparam int DLY_A_GAMMA = 20;
    localparam int DLY_A_END   = 100;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RST_HI,
        PH_RST_LO,
        PH_SETTLE,
        PH_ID_WAIT,
        PH_OPC,
        PH_OPC_WAIT,
        PH_PRM,
        PH_PRM_WAIT,
        PH_DLY
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [STEP_W-1:0]   step;
        logic [PIDX_W-1:0]   pidx;
        logic                prog_b;
        logic                reset_n;
        logic                busy;
        logic                done;
        logic                err;
    } seq_state_s;

endpackage

// File: rtl/pis_ms_timer.sv
module pis_ms_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // Each tick outside a load removes exactly one millisecond
    assert_tick_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && tick_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // Without tick or load the count holds
    assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pis_step_rom.sv
module pis_step_rom
    import panel_init_pkg::*;
#(
    parameter int TMR_W     = 8,
    parameter int ON_GAP_MS = 100
) (
    input  logic              prog_b_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [PIDX_W-1:0] pidx_i,
    output logic [BYTE_W-1:0] opcode_o,
    output logic [PIDX_W-1:0] count_o,
    output logic [TMR_W-1:0]  delay_o,
    output logic [BYTE_W-1:0] param_o,
    output logic              last_o
);

    localparam logic [STEP_W-1:0] LEN_A = STEP_W'(PROG_A_LEN);
    localparam logic [STEP_W-1:0] LEN_B = STEP_W'(PROG_B_LEN);

    logic [STEP_W-1:0] prog_len;
    logic [STEP_W-1:0] tail_idx;
    logic              in_prog;

    always_comb begin
        prog_len = prog_b_i ? LEN_B : LEN_A;
        in_prog  = (step_i < prog_len);
        tail_idx = step_i - prog_len;

        opcode_o = '0;
        count_o  = '0;
        delay_o  = '0;
        param_o  = {step_i[3:0], pidx_i[3:0]};
        last_o   = 1'b0;

        if (in_prog && !prog_b_i) begin
            unique case (step_i[2:0])
                3'd0: begin opcode_o = 8'h36; count_o = PIDX_W'(1);  end
                3'd1: begin opcode_o = 8'h3A; count_o = PIDX_W'(1);  end
                3'd2: begin opcode_o = 8'hB6; count_o = PIDX_W'(4);  end
                3'd3: begin opcode_o = 8'hC5; count_o = PIDX_W'(2);  end
                3'd4: begin opcode_o = 8'hE0; count_o = PIDX_W'(16); end
                3'd5: begin
                    opcode_o = 8'hE1;
                    count_o  = PIDX_W'(16);
                    delay_o  = TMR_W'(DLY_A_GAMMA);
                end
                3'd6: begin opcode_o = 8'hB0; count_o = PIDX_W'(1);  end
                default: begin
                    opcode_o = 8'hB4;
                    count_o  = PIDX_W'(1);
                    delay_o  = TMR_W'(DLY_A_END);
                end
            endcase
        end else if (in_prog) begin
            if (step_i == '0) begin
                opcode_o = 8'hFF;
                count_o  = PIDX_W'(3);
                unique case (pidx_i)
                    PIDX_W'(0): param_o = 8'hFF;
                    PIDX_W'(1): param_o = 8'h98;
                    default:    param_o = 8'h06;
                endcase
            end else if (step_i == LEN_B - STEP_W'(1)) begin
                opcode_o = 8'h35;
                count_o  = PIDX_W'(1);
                param_o  = 8'h00;
            end else begin
                opcode_o = 8'hC0 + BYTE_W'(step_i);
                count_o  = PIDX_W'(2);
            end
        end else begin
            if (tail_idx == '0) begin
                opcode_o = OPC_DISP_ON;
                delay_o  = TMR_W'(ON_GAP_MS);
            end else begin
                opcode_o = OPC_SLEEP_OUT;
                last_o   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pis_xfer_link.sv
module pis_xfer_link
    import panel_init_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              issue_i,
    input  logic              issue_rd_i,
    input  logic [WORD_W-1:0] issue_word_i,
    output logic              req_o,
    output logic              rd_o,
    output logic [WORD_W-1:0] word_o,
    input  logic              port_done_i,
    input  logic              port_err_i,
    input  logic [BYTE_W-1:0] port_rdata_i,
    output logic              done_o,
    output logic              err_o,
    output logic [BYTE_W-1:0] rdata_o
);

    typedef struct packed {
        logic              req;
        logic              rd;
        logic [WORD_W-1:0] word;
    } link_s;

    link_s l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (l_q.req && port_done_i) begin
            l_d.req = 1'b0;
        end
        if (issue_i) begin
            l_d.req  = 1'b1;
            l_d.rd   = issue_rd_i;
            l_d.word = issue_word_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) l_q <= '0;
        else         l_q <= l_d;
    end

    assign req_o   = l_q.req;
    assign rd_o    = l_q.rd;
    assign word_o  = l_q.word;
    assign done_o  = l_q.req & port_done_i;
    assign err_o   = done_o & port_err_i;
    assign rdata_o = port_rdata_i;

    // A new transfer never starts while one is outstanding
    assert_single_outstanding_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_i |-> !l_q.req);

    // Request and word hold until the port answers
    assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (l_q.req && !port_done_i) |=> (l_q.req && $stable(l_q.word) && $stable(l_q.rd)));

    // Request drops right after the answer
    assert_req_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (l_q.req && port_done_i && !issue_i) |=> !l_q.req);

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import panel_init_pkg::*;
#(
    parameter int          TMR_W         = 8,
    parameter int          RST_HIGH_MS   = 100,
    parameter int          RST_LOW_MS    = 40,
    parameter int          RST_SETTLE_MS = 100,
    parameter int          ON_GAP_MS     = 100,
    parameter logic [7:0]  ID_MATCH      = 8'h80,
    parameter logic [7:0]  ID_OPCODE     = 8'h04
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        start_i,
    input  logic        ms_tick_i,
    output logic        panel_rst_n_o,
    output logic        xfer_req_o,
    output logic        xfer_rd_o,
    output logic [8:0]  xfer_word_o,
    input  logic        xfer_done_i,
    input  logic        xfer_err_i,
    input  logic [7:0]  xfer_rdata_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);

    localparam logic [STEP_W-1:0] STEP_LIMIT = STEP_W'(STEP_MAX);

    seq_state_s s_d, s_q;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;

    logic              lk_issue;
    logic              lk_rd;
    logic [WORD_W-1:0] lk_word;
    logic              lk_done;
    logic              lk_err;
    logic [BYTE_W-1:0] lk_rdata;

    logic [BYTE_W-1:0] rom_opcode;
    logic [PIDX_W-1:0] rom_count;
    logic [TMR_W-1:0]  rom_delay;
    logic [BYTE_W-1:0] rom_param;
    logic              rom_last;

    pis_ms_timer #(.CNT_W(TMR_W)) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (ms_tick_i),
        .zero_o     (tmr_zero)
    );

    pis_step_rom #(.TMR_W(TMR_W), .ON_GAP_MS(ON_GAP_MS)) u_rom (
        .prog_b_i (s_q.prog_b),
        .step_i   (s_q.step),
        .pidx_i   (s_q.pidx),
        .opcode_o (rom_opcode),
        .count_o  (rom_count),
        .delay_o  (rom_delay),
        .param_o  (rom_param),
        .last_o   (rom_last)
    );

    pis_xfer_link u_link (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .issue_i      (lk_issue),
        .issue_rd_i   (lk_rd),
        .issue_word_i (lk_word),
        .req_o        (xfer_req_o),
        .rd_o         (xfer_rd_o),
        .word_o       (xfer_word_o),
        .port_done_i  (xfer_done_i),
        .port_err_i   (xfer_err_i),
        .port_rdata_i (xfer_rdata_i),
        .done_o       (lk_done),
        .err_o        (lk_err),
        .rdata_o      (lk_rdata)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        lk_issue = 1'b0;
        lk_rd    = 1'b0;
        lk_word  = '0;

        unique case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase   = PH_RST_HI;
                    s_d.busy    = 1'b1;
                    s_d.err     = 1'b0;
                    s_d.reset_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(RST_HIGH_MS);
                end
            end
            PH_RST_HI: begin
                if (tmr_zero) begin
                    s_d.phase   = PH_RST_LO;
                    s_d.reset_n = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(RST_LOW_MS);
                end
            end
            PH_RST_LO: begin
                if (tmr_zero) begin
                    s_d.phase   = PH_SETTLE;
                    s_d.reset_n = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(RST_SETTLE_MS);
                end
            end
            PH_SETTLE: begin
                if (tmr_zero) begin
                    s_d.phase = PH_ID_WAIT;
                    lk_issue  = 1'b1;
                    lk_rd     = 1'b1;
                    lk_word   = {1'b0, ID_OPCODE};
                end
            end
            PH_ID_WAIT: begin
                if (lk_done) begin
                    s_d.prog_b = (lk_rdata != ID_MATCH);
                    s_d.err    = s_q.err | lk_err;
                    s_d.step   = '0;
                    s_d.phase  = PH_OPC;
                end
            end
            PH_OPC: begin
                lk_issue  = 1'b1;
                lk_word   = {1'b0, rom_opcode};
                s_d.pidx  = '0;
                s_d.phase = PH_OPC_WAIT;
            end
            PH_OPC_WAIT: begin
                if (lk_done) begin
                    s_d.err = s_q.err | lk_err;
                    if (rom_count == '0) begin
                        tmr_load  = 1'b1;
                        tmr_val   = rom_delay;
                        s_d.phase = PH_DLY;
                    end else begin
                        s_d.phase = PH_PRM;
                    end
                end
            end
            PH_PRM: begin
                lk_issue  = 1'b1;
                lk_word   = {1'b1, rom_param};
                s_d.phase = PH_PRM_WAIT;
            end
            PH_PRM_WAIT: begin
                if (lk_done) begin
                    s_d.err = s_q.err | lk_err;
                    if ((s_q.pidx + PIDX_W'(1)) == rom_count) begin
                        tmr_load  = 1'b1;
                        tmr_val   = rom_delay;
                        s_d.phase = PH_DLY;
                    end else begin
                        s_d.pidx  = s_q.pidx + PIDX_W'(1);
                        s_d.phase = PH_PRM;
                    end
                end
            end
            PH_DLY: begin
                if (tmr_zero) begin
                    if (rom_last) begin
                        s_d.phase = PH_IDLE;
                        s_d.busy  = 1'b0;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.step  = s_q.step + STEP_W'(1);
                        s_d.phase = PH_OPC;
                    end
                end
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q         <= '0;
            s_q.phase   <= PH_IDLE;
            s_q.reset_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign panel_rst_n_o = s_q.reset_n;
    assign busy_o        = s_q.busy;
    assign done_o        = s_q.done;
    assign err_o         = s_q.err;

    // No command traffic while the panel is held in reset
    assert_quiet_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !panel_rst_n_o |-> !xfer_req_o);

    // Done comes with busy low, right after a busy cycle, and lasts one cycle
    assert_done_shape_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && $past(busy_o)));
    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // Error flag cannot fall during a run
    assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && err_o) |=> err_o);

    // A start while busy does not bring back the first reset phase
    assert_restart_blocked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && (s_q.phase != PH_IDLE)) |=> (s_q.phase != PH_RST_HI || $past(s_q.phase) == PH_RST_HI));

    // Step index stays inside the stored programs plus tail
    assert_step_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (s_q.step < STEP_LIMIT));

endmodule

// File: tb/panel_init_seq_test.sv
module panel_init_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic       done_in = 1'b0;
    logic       err_in = 1'b0;
    logic [7:0] rdata_in = 8'h00;

    logic       panel_rstn;
    logic       req;
    logic       rd;
    logic [8:0] word;
    logic       busy;
    logic       done;
    logic       err;

    always #4 clk = ~clk;

    panel_init_seq uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .ms_tick_i     (tick),
        .panel_rst_n_o (panel_rstn),
        .xfer_req_o    (req),
        .xfer_rd_o     (rd),
        .xfer_word_o   (word),
        .xfer_done_i   (done_in),
        .xfer_err_i    (err_in),
        .xfer_rdata_i  (rdata_in),
        .busy_o        (busy),
        .done_o        (done),
        .err_o         (err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_total = 0;
    int start_snap = 0;
    int fall_snap = 0;
    int last_done_snap = 0;
    int word_idx = 0;
    int err_at = -1;
    int lat = 0;
    int done_cnt = 0;
    bit serving = 1'b0;
    bit prev_busy = 1'b0;
    bit prev_rstn = 1'b1;
    bit finished = 1'b0;
    logic [7:0] id_val = 8'h00;

    int    exp_word[$];
    int    exp_gap[$];
    string exp_tag[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input int w, input int g, input string tag);
        exp_word.push_back(w);
        exp_gap.push_back(g);
        exp_tag.push_back(tag);
    endtask

    // Driver side: expected stream from the requirements
    task automatic build(input logic [7:0] id);
        int a_opc [8] = '{8'h36, 8'h3A, 8'hB6, 8'hC5, 8'hE0, 8'hE1, 8'hB0, 8'hB4};
        int a_cnt [8] = '{1, 1, 4, 2, 16, 16, 1, 1};
        push(32'h204, 100, "R3 id read, R2 settle");
        if (id == 8'h80) begin
            for (int e = 0; e < 8; e++) begin
                push(a_opc[e], (e == 6) ? 20 : -1, (e == 6) ? "R7 gamma wait" : "R4 opcode");
                for (int k = 0; k < a_cnt[e]; k++)
                    push(32'h100 | ((e & 15) << 4) | k, -1, "R6 param");
            end
            push(32'h029, 100, "R8 display on, R7 end wait");
        end else begin
            push(32'h0FF, -1, "R5 first opcode");
            push(32'h1FF, -1, "R5 first param");
            push(32'h198, -1, "R5 first param");
            push(32'h106, -1, "R5 first param");
            for (int e = 1; e < 21; e++) begin
                push(32'hC0 + e, -1, "R5 filler opcode");
                for (int k = 0; k < 2; k++)
                    push(32'h100 | ((e & 15) << 4) | k, -1, "R6 param");
            end
            push(32'h035, -1, "R5 last opcode");
            push(32'h100, -1, "R5 last param");
            push(32'h029, -1, "R8 display on");
        end
        push(32'h011, 100, "R8 sleep out gap");
    endtask

    always @(posedge clk) begin
        if (tick) tick_total++;
    end

    // Tick source, port model and monitor
    always @(negedge clk) begin
        int got, e, g;
        string t;
        cyc++;
        tick = ((cyc % 5) == 4);
        if (rst_n) begin
            if (busy && !prev_busy) start_snap = tick_total;
            if (!panel_rstn && prev_rstn) begin
                check((tick_total - start_snap) == 100, "R2 first high phase", tick_total - start_snap, 100);
                fall_snap = tick_total;
            end
            if (panel_rstn && !prev_rstn) begin
                check((tick_total - fall_snap) == 40, "R2 low phase", tick_total - fall_snap, 40);
                last_done_snap = tick_total;
            end
            prev_busy = busy;
            prev_rstn = panel_rstn;

            if (done) begin
                done_cnt++;
                check(!busy, "R9 busy low at done", busy, 0);
                check(exp_word.size() == 0, "R9 stream complete at done", exp_word.size(), 0);
            end

            if (done_in) begin
                done_in = 1'b0;
                err_in = 1'b0;
                last_done_snap = tick_total;
            end
            if (serving) begin
                lat--;
                if (lat == 0) begin
                    done_in = 1'b1;
                    err_in = ((word_idx - 1) == err_at);
                    rdata_in = id_val;
                    serving = 1'b0;
                end
            end else if (req) begin
                got = int'({rd, word});
                serving = 1'b1;
                lat = 2;
                word_idx++;
                if (exp_word.size() == 0) begin
                    check(1'b0, "R12 unexpected transfer", got, 0);
                end else begin
                    e = exp_word.pop_front();
                    g = exp_gap.pop_front();
                    t = exp_tag.pop_front();
                    check(got == e, t, got, e);
                    if (g >= 0)
                        check((tick_total - last_done_snap) == g, {t, " ticks"}, tick_total - last_done_snap, g);
                end
            end
        end
    end

    task automatic run(input logic [7:0] id, input int eat, input bit poke);
        int d0;
        d0 = done_cnt;
        id_val = id;
        err_at = eat;
        word_idx = 0;
        build(id);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy after start", busy, 1);
        if (eat < 0) check(err == 1'b0, "R10 flag cleared by start", err, 0);
        if (poke) begin
            wait (!panel_rstn);
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(panel_rstn == 1'b0, "R11 reset line unchanged by late start", panel_rstn, 0);
            wait (word_idx >= 8);
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (5) @(negedge clk);
        check(done_cnt == d0 + 1, "R9 R11 single done pulse", done_cnt - d0, 1);
        check(exp_word.size() == 0, "R12 queue drained", exp_word.size(), 0);
        check(err == (eat >= 0), "R10 error flag at end", err, (eat >= 0));
        check(req == 1'b0 && busy == 1'b0, "R9 idle after done", {req, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(panel_rstn == 1'b1, "R1 reset line idle high", panel_rstn, 1);
        check(req == 1'b0, "R1 no request", req, 0);
        check(busy == 1'b0 && done == 1'b0, "R1 busy and done low", {busy, done}, 0);
        check(err == 1'b0, "R1 error low", err, 0);

        run(8'h80, -1, 1'b1);   // program A with restart pokes
        run(8'h33, -1, 1'b0);   // program B
        run(8'h80, 3, 1'b0);    // error on an entry of program A
        run(8'h7F, -1, 1'b0);   // flag cleared, program B

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule